// File: doc/BRIEF.md
# Page Table Translation Unit

This block converts a virtual byte address into a physical byte address through a single-level page table kept in internal registers. The upper bits of the virtual address select a table entry and the lower bits pass through as the byte offset inside a frame. Each entry records which physical frame backs the page, whether the page is resident, and a small set of attribute flags. A resident page yields the frame's base address plus the offset. A non-resident page raises a page-fault indication instead of an address.

After reset the unit fills its own table with one entry per clock. Pages are assigned to frames in rotation: the frame number wraps to zero once every physical frame has been used. Only the pages that fit in main memory start resident. While this fill runs, a busy output is high and all requests are ignored. Once the table is ready, an external replacement controller can set or clear the resident bit of any single entry through a dedicated update port. Lookups take one registered cycle.

Top module: `page_xlate_unit`

## Requirements
- R1: With the defaults (20-bit virtual address, 4096-byte frames, 40960-byte memory) the page number is reqVaddr[19:12], the offset is reqVaddr[11:0], and respPaddr is 16 bits wide, formed as frame number times 4096 plus the offset, that is {frame[3:0], offset[11:0]}.
- R2: busy is high during reset and for exactly 256 clock cycles after reset is released (one cycle per table entry), then low.
- R3: After the fill, page p maps to frame (p mod 10), and page p is resident only when p < 10.
- R4: A lookup of a resident page returns respPageFault = 0 and respPaddr = frame*4096 + offset; a lookup of a non-resident page returns respPageFault = 1 and respPaddr = 0.
- R5: respValid is high in the cycle after an accepted request and low in a cycle that follows no accepted request.
- R6: While busy is high, lookup requests are ignored: respValid stays low.
- R7: An update writes updPresent into the resident bit of entry updPage in one cycle; a lookup of the same page in the same cycle sees the value from before the update.
- R8: While busy is high, updates are ignored and do not change any entry.
- R9: Every entry's attribute flags (persistence, dirty, read, write, modify) are zero after the fill, and respAttr returns them with each response.
- R10: An update changes only the addressed entry; other entries keep their frame and resident bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 20 | Virtual byte address to translate |
| updValid | input | 1 | Resident-bit update strobe |
| updPage | input | 8 | Page number whose resident bit is written |
| updPresent | input | 1 | New resident-bit value |
| busy | output | 1 | Table fill in progress; requests ignored |
| respValid | output | 1 | Response valid, one cycle after the request |
| respPaddr | output | 16 | Physical byte address, zero on a fault |
| respPageFault | output | 1 | Page-fault indication for the response |
| respAttr | output | 5 | Attribute flags of the looked-up entry |

## Verification
The bench goes after the wrap of the frame assignment at page 10, the resident boundary between pages 9 and 10, and the largest offset in a frame; a design that computed the frame with the wrong modulus or marked one page too many resident would return a wrong address or a missing fault there. It counts the busy cycles exactly, so a fill that ends one cycle early or late is caught, and it issues requests and an update during the fill: a design that accepted them would produce a response while busy or lose the resident bit of page 0. It also applies an update and a lookup to the same page in one cycle, where a design that forwarded the new bit would fault instead of returning the old address, and it checks that neighbouring pages are untouched by updates.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic initWr;       // write the fill entry this cycle
    logic initPresent;  // resident bit for the fill entry
    logic lookupEn;     // accept the lookup request
    logic updEn;        // accept the resident-bit update
  } ptwStrobe_t;

  // Per-entry attribute flags
  typedef struct packed {
    logic persist;
    logic dirty;
    logic rdOk;
    logic wrOk;
    logic modOk;
  } pteAttr_t;

  localparam int ATTR_W = $bits(pteAttr_t);

  typedef enum logic [0:0] {
    ST_FILL = 1'b0,
    ST_RUN  = 1'b1
  } ptwState_e;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int PN_W       = 8,
  parameter int FRAME_W    = 4,
  parameter int NUM_PAGES  = 256,
  parameter int NUM_FRAMES = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               updValid,
  output logic               busy,
  output logic [PN_W-1:0]    fillIdx,
  output logic [FRAME_W-1:0] fillFrame,
  output ptwStrobe_t         stb
);

  localparam logic [PN_W-1:0]    LAST_PAGE  = PN_W'(NUM_PAGES - 1);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);

  ptwState_e state;

  // Fill walk: one entry per clock, frame number rotates through memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_FILL;
      fillIdx   <= '0;
      fillFrame <= '0;
    end else if (state == ST_FILL) begin
      fillIdx   <= fillIdx + 1'b1;
      fillFrame <= (fillFrame == LAST_FRAME) ? '0 : fillFrame + 1'b1;
      if (fillIdx == LAST_PAGE) begin
        state <= ST_RUN;
      end
    end
  end

  assign busy = (state == ST_FILL);

  always_comb begin
    stb             = '0;
    stb.initWr      = (state == ST_FILL);
    stb.initPresent = (32'(fillIdx) < NUM_FRAMES);
    stb.lookupEn    = reqValid && (state == ST_RUN);
    stb.updEn       = updValid && (state == ST_RUN);
  end

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int PN_W      = 8,
  parameter int OFF_W     = 12,
  parameter int FRAME_W   = 4,
  parameter int NUM_PAGES = 256
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ptwStrobe_t              stb,
  input  logic [PN_W-1:0]         fillIdx,
  input  logic [FRAME_W-1:0]      fillFrame,
  input  logic [PN_W+OFF_W-1:0]   reqVaddr,
  input  logic [PN_W-1:0]         updPage,
  input  logic                    updPresent,
  output logic                    respValid,
  output logic [FRAME_W+OFF_W-1:0] respPaddr,
  output logic                    respPageFault,
  output logic [ATTR_W-1:0]       respAttr
);

  // Table storage, filled by the walk rather than by reset
  logic [FRAME_W-1:0] frameTab [NUM_PAGES];
  logic               presTab  [NUM_PAGES];
  pteAttr_t           attrTab  [NUM_PAGES];

  logic [PN_W-1:0]  reqPage;
  logic [OFF_W-1:0] reqOff;

  assign reqPage = reqVaddr[PN_W+OFF_W-1:OFF_W];
  assign reqOff  = reqVaddr[OFF_W-1:0];

  // Table writes: fill walk or single-entry resident update
  always_ff @(posedge clk) begin
    if (stb.initWr) begin
      frameTab[fillIdx] <= fillFrame;
      presTab[fillIdx]  <= stb.initPresent;
      attrTab[fillIdx]  <= '0;
    end else if (stb.updEn) begin
      presTab[updPage]  <= updPresent;
    end
  end

  // Registered lookup; reads see the table before this edge's write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respPaddr     <= '0;
      respPageFault <= 1'b0;
      respAttr      <= '0;
    end else begin
      respValid <= stb.lookupEn;
      if (stb.lookupEn) begin
        if (presTab[reqPage]) begin
          respPaddr     <= {frameTab[reqPage], reqOff};
          respPageFault <= 1'b0;
          respAttr      <= attrTab[reqPage];
        end else begin
          respPaddr     <= '0;
          respPageFault <= 1'b1;
          respAttr      <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import ptw_pkg::*;
#(
  parameter int VA_W        = 20,
  parameter int FRAME_BYTES = 4096,
  parameter int MEM_BYTES   = 40960,
  localparam int OFF_W      = $clog2(FRAME_BYTES),
  localparam int PN_W       = VA_W - OFF_W,
  localparam int NUM_FRAMES = MEM_BYTES / FRAME_BYTES,
  localparam int FRAME_W    = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int PA_W       = FRAME_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              updValid,
  input  logic [PN_W-1:0]   updPage,
  input  logic              updPresent,
  output logic              busy,
  output logic              respValid,
  output logic [PA_W-1:0]   respPaddr,
  output logic              respPageFault,
  output logic [ATTR_W-1:0] respAttr
);

  localparam int NUM_PAGES = 1 << PN_W;

  // Configuration rules checked at elaboration
  if ((VA_W % 4) != 0) begin : g_badVaWidth
    $error("virtual address width must be a multiple of 4");
  end
  if ((FRAME_BYTES % 2) != 0 || (MEM_BYTES % 2) != 0) begin : g_badEven
    $error("frame and memory sizes must be even");
  end
  if ((MEM_BYTES % FRAME_BYTES) != 0) begin : g_badMultiple
    $error("memory size must be a multiple of the frame size");
  end
  if (OFF_W > VA_W) begin : g_badFrameFit
    $error("a frame must fit inside the virtual address range");
  end

  ptwStrobe_t         stb;
  logic [PN_W-1:0]    fillIdx;
  logic [FRAME_W-1:0] fillFrame;

  ptw_ctrl #(
    .PN_W      (PN_W),
    .FRAME_W   (FRAME_W),
    .NUM_PAGES (NUM_PAGES),
    .NUM_FRAMES(NUM_FRAMES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .updValid (updValid),
    .busy     (busy),
    .fillIdx  (fillIdx),
    .fillFrame(fillFrame),
    .stb      (stb)
  );

  ptw_datapath #(
    .PN_W     (PN_W),
    .OFF_W    (OFF_W),
    .FRAME_W  (FRAME_W),
    .NUM_PAGES(NUM_PAGES)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .fillIdx      (fillIdx),
    .fillFrame    (fillFrame),
    .reqVaddr     (reqVaddr),
    .updPage      (updPage),
    .updPresent   (updPresent),
    .respValid    (respValid),
    .respPaddr    (respPaddr),
    .respPageFault(respPageFault),
    .respAttr     (respAttr)
  );

endmodule

// File: rtl/page_xlate_unit_chk.sv
module page_xlate_unit_chk #(
  parameter int VA_W      = 20,
  parameter int OFF_W     = 12,
  parameter int PA_W      = 16,
  parameter int ATTR_W    = 5,
  parameter int NUM_PAGES = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [VA_W-1:0]   reqVaddr,
  input logic              busy,
  input logic              respValid,
  input logic [PA_W-1:0]   respPaddr,
  input logic              respPageFault,
  input logic [ATTR_W-1:0] respAttr
);

  // Clock edges since reset release, saturating past the fill length
  logic [$clog2(NUM_PAGES):0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (32'(sinceRst) < NUM_PAGES) sinceRst <= sinceRst + 1'b1;
  end

  // R2: busy lasts exactly one cycle per table entry
  a_r2_busy_window: assert property (@(posedge clk) disable iff (!rstN)
    busy == (32'(sinceRst) < NUM_PAGES));

  // R6: no response for a request made while busy
  a_r6_no_resp_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |=> !respValid);

  // R5: accepted request gives a response next cycle
  a_r5_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> respValid);

  // R5: no response without an accepted request
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !busy) |=> !respValid);

  // R4: a fault carries a zero address
  a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respPageFault) |-> (respPaddr == '0));

  // R1: offset passes through unchanged on a resident page
  a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=>
      (respPageFault || respPaddr[OFF_W-1:0] == $past(reqVaddr[OFF_W-1:0])));

  // R9: attribute flags read back as zero
  a_r9_attr_zero: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respAttr == '0));

endmodule

bind page_xlate_unit page_xlate_unit_chk #(
  .VA_W     (VA_W),
  .OFF_W    (OFF_W),
  .PA_W     (PA_W),
  .ATTR_W   (ptw_pkg::ATTR_W),
  .NUM_PAGES(1 << PN_W)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqVaddr     (reqVaddr),
  .busy         (busy),
  .respValid    (respValid),
  .respPaddr    (respPaddr),
  .respPageFault(respPageFault),
  .respAttr     (respAttr)
);

// File: tb/page_xlate_unit_tb_top.sv
module page_xlate_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [19:0] reqVaddr;
  logic        updValid;
  logic [7:0]  updPage;
  logic        updPresent;
  logic        busy;
  logic        respValid;
  logic [15:0] respPaddr;
  logic        respPageFault;
  logic [4:0]  respAttr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  page_xlate_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .updValid(updValid), .updPage(updPage), .updPresent(updPresent),
    .busy(busy), .respValid(respValid), .respPaddr(respPaddr),
    .respPageFault(respPageFault), .respAttr(respAttr)
  );

  typedef struct packed {
    logic [19:0] va;
    logic        fault;
    logic [15:0] pa;
  } vec_t;

  // Post-fill lookups with expected results (R1, R3, R4)
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{va: 20'h00ABC, fault: 1'b0, pa: 16'h0ABC},
    '{va: 20'h01001, fault: 1'b0, pa: 16'h1001},
    '{va: 20'h05000, fault: 1'b0, pa: 16'h5000},
    '{va: 20'h09FFF, fault: 1'b0, pa: 16'h9FFF},
    '{va: 20'h0A123, fault: 1'b1, pa: 16'h0000},
    '{va: 20'h0B001, fault: 1'b1, pa: 16'h0000},
    '{va: 20'hFF7FF, fault: 1'b1, pa: 16'h0000},
    '{va: 20'h08000, fault: 1'b0, pa: 16'h8000}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Issue one lookup, sample its response one cycle later
  task automatic lookup(input logic [19:0] va);
    @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic update(input logic [7:0] pg, input logic pres);
    @(negedge clk);
    updValid   = 1'b1;
    updPage    = pg;
    updPresent = pres;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic expectResp(input string tag, input logic fault, input logic [15:0] pa);
    check(respValid == 1'b1, {tag, " valid"}, int'(respValid), 1);
    check(respPageFault == fault, {tag, " fault"}, int'(respPageFault), int'(fault));
    check(respPaddr == pa, {tag, " paddr"}, int'(respPaddr), int'(pa));
    check(respAttr == 5'd0, "R9 attr", int'(respAttr), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int busyCnt;
    bit sawResp;
    rstN = 1'b0; reqValid = 1'b0; reqVaddr = '0;
    updValid = 1'b0; updPage = '0; updPresent = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R2 busy in reset", int'(busy), 1);
    check(respValid == 1'b0, "R5 no resp in reset", int'(respValid), 0);

    // Release reset; request and update during the fill (R6, R8)
    rstN = 1'b1;
    reqValid = 1'b1;
    reqVaddr = 20'h00123;
    busyCnt = 0;
    sawResp = 1'b0;
    while (busy && busyCnt < 1000) begin
      busyCnt++;
      if (respValid) sawResp = 1'b1;
      updValid   = (busyCnt == 100);
      updPage    = 8'h00;
      updPresent = 1'b0;
      @(negedge clk);
    end
    if (respValid) sawResp = 1'b1;
    reqValid = 1'b0;
    updValid = 1'b0;
    check(busyCnt == 256, "R2 busy cycles", busyCnt, 256);
    check(sawResp == 1'b0, "R6 resp while busy", int'(sawResp), 0);

    // R8: page 0 must still be resident despite the clear during the fill
    lookup(20'h00123);
    expectResp("R8 page0 kept", 1'b0, 16'h0123);

    // Vector table walk (R1, R3, R4)
    for (int i = 0; i < NVEC; i++) begin
      lookup(VECS[i].va);
      expectResp("R4 vector", VECS[i].fault, VECS[i].pa);
    end

    // R5: idle cycle gives no response
    @(negedge clk);
    check(respValid == 1'b0, "R5 idle", int'(respValid), 0);

    // R7 / R3: make page 11 resident; wraps to frame 1
    update(8'h0B, 1'b1);
    lookup(20'h0B456);
    expectResp("R7 set page11 (R3 wrap)", 1'b0, 16'h1456);

    // R3: page 19 maps to frame 9
    update(8'h13, 1'b1);
    lookup(20'h13800);
    expectResp("R3 page19 frame9", 1'b0, 16'h9800);

    // R7: clear page 3
    update(8'h03, 1'b0);
    lookup(20'h03FFF);
    expectResp("R7 clear page3", 1'b1, 16'h0000);

    // R10: neighbours untouched
    lookup(20'h02ABC);
    expectResp("R10 page2 kept", 1'b0, 16'h2ABC);
    lookup(20'h0C000);
    expectResp("R10 page12 still absent", 1'b1, 16'h0000);

    // R7: same-cycle update and lookup of page 4 sees the old bit
    @(negedge clk);
    updValid = 1'b1; updPage = 8'h04; updPresent = 1'b0;
    reqValid = 1'b1; reqVaddr = 20'h04010;
    @(negedge clk);
    updValid = 1'b0; reqValid = 1'b0;
    expectResp("R7 same-cycle old value", 1'b0, 16'h4010);
    lookup(20'h04010);
    expectResp("R7 after same-cycle clear", 1'b1, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule